// File: doc/BRIEF.md
# Multiframe-Aligned Lane Release Controller

This block sits on the receive side of a multi-lane converter link and gives the link a latency that does not change from one power-up to the next. It keeps a frame-rate counter that wraps every K frames. The counter value zero marks the local multiframe boundary. A shared timing reference pulse, the sync reference, forces the counter back to zero. Every device that sees the same pulse therefore holds the same multiframe phase.

Each lane writes its frame-rate words into a small circular buffer. All buffers are read together, starting at a fixed release frame. That frame lies a programmable number of frames (the release offset) after the multiframe boundary. Lane skew shorter than the gap to the release frame is absorbed, and the output timing depends only on the reference pulse and the configuration. If a lane is still missing at the release frame, release is put off to the next multiframe and an error is flagged. Writing into a full buffer raises a sticky overflow error.

Realignment can be accepted on every reference pulse, or only on the first pulse after the realignment enable is raised.

Top module: `lmfc_release_ctrl`

## Requirements
- R1: The frame counter advances once per clock and wraps to zero after value `cfg_k`-1. `lmfc_edge` is high exactly in the frames where the counter is zero, so it is high in one frame out of every `cfg_k`. It is also high during reset.
- R2: When `sysref_en` is high and not in one-shot mode, a `sysref` rising edge is taken. If `sysref` is sampled high at clock edge n after being low at edge n-1, then after edge n+1 the counter is zero and `lmfc_edge` is high.
- R3: While `sysref_en` is low, `sysref` pulses are ignored and the counter keeps its free-running phase.
- R4: With `oneshot_mode` high, only the first `sysref` edge taken after reset, or after `sysref_en` has been low for at least one clock, realigns the counter. Later pulses are ignored until `sysref_en` is lowered again.
- R5: The release frame is the frame where the counter equals the effective offset. The effective offset is `cfg_rbd`, with 0 treated as 1. An offset of `cfg_k` or more gives counter value 0, which is the multiframe boundary. `release_pulse` is high for the one clock that follows the release frame, and `out_valid` rises in that same clock.
- R6: Release happens only once every lane has written at least one word. In the first `out_valid` clock, the first word of every lane appears together on `out_data`, with lane i in bits [i*DW +: DW]. Later words follow one per clock, and `out_valid` stays high.
- R7: At a release frame where at least one lane, but not all lanes, has started writing, `late_err` is set and release moves to a later release frame. `late_err` is sticky until reset.
- R8: A write to a lane buffer that already holds DEPTH words and is not being read drops that word and sets `ovf_err`. `ovf_err` is sticky until reset.
- R9: During and right after reset, `out_valid`, `release_pulse`, `late_err` and `ovf_err` are low.
- R10: For a fixed reference timing, `cfg_k` and `cfg_rbd`, the clock in which `release_pulse` rises depends only on the start of the latest lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lane_data | input | LANES*DW | Per-lane incoming words, lane i at [i*DW +: DW] |
| lane_valid | input | LANES | Per-lane word-valid flags |
| sysref | input | 1 | Shared timing reference pulse |
| sysref_en | input | 1 | Permits realignment from the reference |
| oneshot_mode | input | 1 | Accept only the first reference edge after enable |
| cfg_k | input | $clog2(KMAX+1) | Frames per multiframe |
| cfg_rbd | input | $clog2(KMAX+1) | Release offset in frames from the boundary |
| out_data | output | LANES*DW | Aligned lane words |
| out_valid | output | 1 | Aligned data is flowing |
| lmfc_edge | output | 1 | Multiframe boundary frame |
| release_pulse | output | 1 | First clock of aligned output |
| late_err | output | 1 | Sticky flag: a lane missed a release frame |
| ovf_err | output | 1 | Sticky lane buffer overflow |

## Verification
Two events can meet in one frame: the release frame, and the arrival of the latest lane's first word. Table rows choose the lane skews so that the last lane's first write lands exactly on the edge that precedes the release frame. That lane then counts as started and release proceeds. In a companion row the last lane arrives one frame later. That lane misses the frame, so `late_err` must be set and `release_pulse` must appear one full multiframe later. Each row is judged by the clock index of the first `release_pulse`, the first word of every lane, and the `late_err` value, all computed in the bench from the offset rule.

// File: rtl/lmfc_pkg.sv
`timescale 1ns/1ps
package lmfc_pkg;
    typedef enum logic [0:0] {
        REL_WAIT = 1'b0,
        REL_RUN  = 1'b1
    } rel_state_e;
endpackage

// File: rtl/lmfc_timer.sv
`timescale 1ns/1ps
module lmfc_timer #(
    parameter int KW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sysref,
    input  logic          sysref_en,
    input  logic          oneshot_mode,
    input  logic [KW-1:0] cfg_k,
    input  logic [KW-1:0] cfg_rbd,
    output logic          lmfc_edge,
    output logic          rel_hit
);
    typedef struct packed {
        logic          sync1;
        logic          sync2;
        logic          armed;
        logic [KW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;
    logic          rise, take;
    logic [KW-1:0] k_last, rbd_eff, rel_idx;

    always_comb begin
        t_d       = t_q;
        t_d.sync1 = sysref;
        t_d.sync2 = t_q.sync1;
        rise      = t_q.sync1 & ~t_q.sync2;
        take      = rise & sysref_en & (t_q.armed | ~oneshot_mode);

        if (!sysref_en)  t_d.armed = 1'b1;
        else if (take)   t_d.armed = 1'b0;

        k_last  = (cfg_k <= KW'(1)) ? '0 : cfg_k - KW'(1);
        rbd_eff = (cfg_rbd == '0) ? KW'(1) : cfg_rbd;
        rel_idx = (rbd_eff >= cfg_k) ? '0 : rbd_eff;

        if (take)                  t_d.cnt = '0;
        else if (t_q.cnt >= k_last) t_d.cnt = '0;
        else                       t_d.cnt = t_q.cnt + KW'(1);

        lmfc_edge = (t_q.cnt == '0);
        rel_hit   = (t_q.cnt == rel_idx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q       <= '0;
            t_q.armed <= 1'b1;
        end else begin
            t_q <= t_d;
        end
    end
endmodule

// File: rtl/lmfc_lane_fifo.sv
`timescale 1ns/1ps
module lmfc_lane_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 32,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          started,
    output logic          overflow
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   fill;
        logic          seen;
    } fifo_t;

    fifo_t f_d, f_q;
    logic [DW-1:0] mem [DEPTH];
    logic full, rd_ok, wr_ok;

    always_comb begin
        f_d      = f_q;
        full     = (f_q.fill == (AW+1)'(DEPTH));
        rd_ok    = rd_en && (f_q.fill != '0);
        wr_ok    = wr_valid && (!full || rd_ok);
        overflow = wr_valid && full && !rd_ok;

        if (wr_ok) begin
            f_d.wp   = (f_q.wp == AW'(DEPTH-1)) ? '0 : f_q.wp + AW'(1);
            f_d.seen = 1'b1;
        end
        if (rd_ok)
            f_d.rp = (f_q.rp == AW'(DEPTH-1)) ? '0 : f_q.rp + AW'(1);
        if (wr_ok && !rd_ok)      f_d.fill = f_q.fill + (AW+1)'(1);
        else if (rd_ok && !wr_ok) f_d.fill = f_q.fill - (AW+1)'(1);

        rd_data = mem[f_q.rp];
        started = f_q.seen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[f_q.wp] <= wr_data;
    end
endmodule

// File: rtl/lmfc_release_ctrl.sv
`timescale 1ns/1ps
module lmfc_release_ctrl #(
    parameter int LANES = 4,
    parameter int DW    = 8,
    parameter int KMAX  = 16,
    parameter int DEPTH = 32,
    localparam int KW   = $clog2(KMAX+1),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LANES*DW-1:0] lane_data,
    input  logic [LANES-1:0]    lane_valid,
    input  logic                sysref,
    input  logic                sysref_en,
    input  logic                oneshot_mode,
    input  logic [KW-1:0]       cfg_k,
    input  logic [KW-1:0]       cfg_rbd,
    output logic [LANES*DW-1:0] out_data,
    output logic                out_valid,
    output logic                lmfc_edge,
    output logic                release_pulse,
    output logic                late_err,
    output logic                ovf_err
);
    import lmfc_pkg::*;

    typedef struct packed {
        rel_state_e st;
        logic       pulse;
        logic       late;
        logic       ovf;
    } ctl_t;

    ctl_t c_d, c_q;
    logic             rel_hit;
    logic [LANES-1:0] lane_started, lane_ovf;
    logic             reading;

    lmfc_timer #(.KW(KW)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .sysref       (sysref),
        .sysref_en    (sysref_en),
        .oneshot_mode (oneshot_mode),
        .cfg_k        (cfg_k),
        .cfg_rbd      (cfg_rbd),
        .lmfc_edge    (lmfc_edge),
        .rel_hit      (rel_hit)
    );

    assign reading = (c_q.st == REL_RUN);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lmfc_lane_fifo #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_valid (lane_valid[g]),
            .wr_data  (lane_data[g*DW +: DW]),
            .rd_en    (reading),
            .rd_data  (out_data[g*DW +: DW]),
            .started  (lane_started[g]),
            .overflow (lane_ovf[g])
        );
    end

    always_comb begin
        c_d       = c_q;
        c_d.pulse = 1'b0;
        if (c_q.st == REL_WAIT && rel_hit) begin
            if (&lane_started) begin
                c_d.st    = REL_RUN;
                c_d.pulse = 1'b1;
            end else if (|lane_started) begin
                c_d.late = 1'b1;
            end
        end
        if (|lane_ovf) c_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: REL_WAIT, pulse: 1'b0, late: 1'b0, ovf: 1'b0};
        else        c_q <= c_d;
    end

    assign out_valid     = reading;
    assign release_pulse = c_q.pulse;
    assign late_err      = c_q.late;
    assign ovf_err       = c_q.ovf;
endmodule

// File: rtl/lmfc_release_ctrl_chk.sv
`timescale 1ns/1ps
module lmfc_release_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic sysref,
    input logic sysref_en,
    input logic oneshot_mode,
    input logic lmfc_edge,
    input logic out_valid,
    input logic release_pulse,
    input logic late_err,
    input logic ovf_err
);
    p_realign_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 3) && $past(sysref, 2) && !$past(sysref, 3) &&
         $past(sysref_en) && !$past(oneshot_mode)) |-> lmfc_edge);

    p_release_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> release_pulse);

    p_stream_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid);

    p_late_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        late_err |=> late_err);

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);

    p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        release_pulse |=> !release_pulse);
endmodule

bind lmfc_release_ctrl lmfc_release_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sysref        (sysref),
    .sysref_en     (sysref_en),
    .oneshot_mode  (oneshot_mode),
    .lmfc_edge     (lmfc_edge),
    .out_valid     (out_valid),
    .release_pulse (release_pulse),
    .late_err      (late_err),
    .ovf_err       (ovf_err)
);

// File: tb/lmfc_release_ctrl_tb.sv
`timescale 1ns/1ps
module lmfc_release_ctrl_tb;
    localparam int LANES = 4;
    localparam int DW    = 8;
    localparam int KMAX  = 16;
    localparam int DEPTH = 32;
    localparam int KW    = $clog2(KMAX+1);
    localparam int NROW  = 8;

    // columns: k, rbd, skew0..skew3, expected release frame m, expected late
    localparam int TBL [NROW][8] = '{
        '{4,  2, 0, 1, 0, 1,  2, 0},
        '{4,  2, 0, 2, 1, 0,  6, 1},
        '{8,  8, 0, 0, 0, 0,  8, 0},
        '{8,  1, 3, 0, 5, 2,  9, 1},
        '{16, 5, 2, 2, 2, 2,  5, 0},
        '{6,  6, 1, 4, 0, 2,  6, 0},
        '{16,16, 0, 3, 7, 1, 16, 0},
        '{4,  0, 0, 0, 0, 0,  1, 0}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [LANES*DW-1:0] lane_data = '0;
    logic [LANES-1:0]    lane_valid = '0;
    logic                sysref = 1'b0;
    logic                sysref_en = 1'b0;
    logic                oneshot_mode = 1'b0;
    logic [KW-1:0]       cfg_k = KW'(8);
    logic [KW-1:0]       cfg_rbd = KW'(8);
    logic [LANES*DW-1:0] out_data;
    logic                out_valid, lmfc_edge, release_pulse, late_err, ovf_err;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    lmfc_release_ctrl #(.LANES(LANES), .DW(DW), .KMAX(KMAX), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .lane_data(lane_data), .lane_valid(lane_valid),
        .sysref(sysref), .sysref_en(sysref_en), .oneshot_mode(oneshot_mode),
        .cfg_k(cfg_k), .cfg_rbd(cfg_rbd), .out_data(out_data), .out_valid(out_valid),
        .lmfc_edge(lmfc_edge), .release_pulse(release_pulse), .late_err(late_err),
        .ovf_err(ovf_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sysref = 1'b0; lane_valid = '0; lane_data = '0;
        step(); step(); step();
        rst_n = 1'b1;
    endtask

    task automatic wait_edge();
        for (int n = 0; n < 40; n++) begin
            step();
            if (lmfc_edge) break;
        end
    endtask

    // pulse sysref right after a boundary; realignment would put a boundary two clocks later
    task automatic probe(input bit take, input string tag);
        wait_edge();
        sysref = 1'b1;
        step();
        step();
        chk(lmfc_edge == take, {tag, " boundary two clocks after pulse"}, lmfc_edge, take);
        sysref = 1'b0;
        for (int n = 0; n < 6; n++) step();
        chk(lmfc_edge == !take, {tag, " boundary at old phase"}, lmfc_edge, !take);
    endtask

    task automatic run_row(input int e);
        int k, m, rel_c;
        logic [LANES*DW-1:0] first_w, second_w;
        k = TBL[e][0];
        m = TBL[e][6];
        rel_c = -1;
        first_w = '0;
        second_w = '0;
        cfg_k = KW'(k);
        cfg_rbd = KW'(TBL[e][1]);
        sysref_en = 1'b1;
        oneshot_mode = 1'b0;
        do_reset();
        step(); step(); step();
        sysref = 1'b1;
        for (int c = 1; c <= 40; c++) begin
            step();
            if (rel_c >= 0 && c == rel_c + 1) second_w = out_data;
            if (rel_c < 0 && release_pulse) begin
                rel_c = c;
                first_w = out_data;
                chk(out_valid == 1'b1, "R5 out_valid with release_pulse", out_valid, 1);
            end
            if (c == 2) chk(lmfc_edge == 1'b1, "R2 realigned boundary", lmfc_edge, 1);
            if (c >= 2) sysref = 1'b0;
            for (int i = 0; i < LANES; i++) begin
                lane_valid[i] = (c >= 2 + TBL[e][2+i]);
                lane_data[i*DW +: DW] = DW'(e*16 + i*4 + (c - 2 - TBL[e][2+i]));
            end
        end
        chk(rel_c == 3 + m, $sformatf("R5 R10 row %0d release clock", e), rel_c, 3 + m);
        for (int i = 0; i < LANES; i++) begin
            chk(first_w[i*DW +: DW] == DW'(e*16 + i*4),
                $sformatf("R6 row %0d lane %0d first word", e, i),
                first_w[i*DW +: DW], e*16 + i*4);
            chk(second_w[i*DW +: DW] == DW'(e*16 + i*4 + 1),
                $sformatf("R6 row %0d lane %0d second word", e, i),
                second_w[i*DW +: DW], e*16 + i*4 + 1);
        end
        chk(late_err == TBL[e][7][0], $sformatf("R7 row %0d late flag", e), late_err, TBL[e][7]);
        chk(ovf_err == 1'b0, $sformatf("R8 row %0d no overflow", e), ovf_err, 0);
        lane_valid = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R9 reset state
        step();
        chk(out_valid == 1'b0, "R9 out_valid in reset", out_valid, 0);
        chk(release_pulse == 1'b0, "R9 release_pulse in reset", release_pulse, 0);
        chk(late_err == 1'b0, "R9 late_err in reset", late_err, 0);
        chk(ovf_err == 1'b0, "R9 ovf_err in reset", ovf_err, 0);
        chk(lmfc_edge == 1'b1, "R1 boundary in reset", lmfc_edge, 1);
        rst_n = 1'b1;

        // R1 boundary period with k=8
        begin
            int first, second, n;
            first = -1; second = -1; n = 0;
            for (int c = 0; c < 30; c++) begin
                step();
                if (lmfc_edge) begin
                    if (first < 0) first = c;
                    else if (second < 0) second = c;
                    n++;
                end
            end
            chk(second - first == 8, "R1 boundary spacing", second - first, 8);
        end

        // table walk: R5 R6 R7 R10
        for (int e = 0; e < NROW; e++) run_row(e);

        // reference handling
        cfg_k = KW'(8); cfg_rbd = KW'(8);
        oneshot_mode = 1'b0; sysref_en = 1'b0;
        do_reset();
        probe(1'b0, "R3 disabled");
        sysref_en = 1'b1;
        probe(1'b1, "R2 continuous first");
        probe(1'b1, "R2 continuous second");
        sysref_en = 1'b0; step();
        oneshot_mode = 1'b1; sysref_en = 1'b1;
        probe(1'b1, "R4 oneshot first");
        probe(1'b0, "R4 oneshot later ignored");
        sysref_en = 1'b0; step(); sysref_en = 1'b1;
        probe(1'b1, "R4 oneshot rearmed");

        // overflow and deferral: only lane 0 ever writes
        cfg_k = KW'(16); cfg_rbd = KW'(15);
        sysref_en = 1'b0; oneshot_mode = 1'b0;
        do_reset();
        lane_valid = 4'b0001;
        for (int c = 0; c < 20; c++) step();
        chk(ovf_err == 1'b0, "R8 no overflow below depth", ovf_err, 0);
        for (int c = 0; c < 20; c++) step();
        chk(ovf_err == 1'b1, "R8 overflow past depth", ovf_err, 1);
        chk(late_err == 1'b1, "R7 partial lanes flag", late_err, 1);
        chk(out_valid == 1'b0, "R7 release deferred", out_valid, 0);
        lane_valid = '0;
        step(); step(); step();
        chk(ovf_err == 1'b1, "R8 overflow sticky", ovf_err, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule